// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Controller

This block streams a fixed 640x480 true-colour image out of memory. It holds a frame base address and a two-bit control word. It walks the visible raster, issues one memory read request per displayed pixel, and splits each returned 32-bit word into 8-bit red, green and blue outputs. Each output pixel comes with a valid strobe and its screen position.

Memory rows are laid out with a fixed power-of-two pitch that is wider than the visible line. The addresses in the margin past the visible width are never requested. The frame base is kept only at coarse alignment, so it selects a buffer and cannot be used for scrolling. A rotate option walks memory backwards over both axes, which turns the picture by 180 degrees.

Software sets up the block through a small 32-bit register port. A strap input selects whether that port is word-indexed or byte-addressed. Register changes are staged and move into the scan only between frames, so a single frame never mixes two configurations.

Top module: `fb_scan_ctrl`

## Requirements
- R1: After reset the block is in this state: display disabled, rotation off, both registers read 0, `rd_valid` low, `pix_valid` low and all colour outputs 0.
- R2: Register decoding works as follows. The base register is at address 0 in both modes. The control register is at address 1 when `cfg_byte_addr`=0 and at address 4 when `cfg_byte_addr`=1. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: With rotation off, the pixel at column x and row y is read from byte address base + y*(ROW_WORDS*4) + x*4. Pixels are requested in raster order: x runs 0..H_VIS-1 inside a row, then y increases. Pitch words at or beyond H_VIS are never requested.
- R4: The base register keeps only the top BASE_KEEP bits (bits 31..21 by default) and reads back with the low bits as 0. In the control register, bit 0 is enable and bit 1 is rotate. It reads back as those two bits, zero-extended.
- R5: With rotation on, the request for screen position (x, y) uses byte address base + (V_VIS-1-y)*(ROW_WORDS*4) + (H_VIS-1-x)*4.
- R6: While the scan is disabled, no read request is issued and the colour outputs stay 0.
- R7: Writes to the base or control register take effect only at the start of the next frame. Every request of a frame that has already started uses the configuration that was active when that frame started.
- R8: A request with `rd_valid` high and `rd_ready` low stays asserted with an unchanged address in the next cycle.
- R9: A returned word on `rsp_valid` yields, one cycle later, `pix_valid` high with red = bits 23..16, green = bits 15..8 and blue = bits 7..0. Bits 31..24 are ignored. `pix_x`/`pix_y` give the screen position, counted in arrival order.
- R10: The last pixel of a frame is (H_VIS-1, V_VIS-1). After it is accepted, the next request is position (0,0) of the following frame, and `rd_valid` stays low for exactly one cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte_addr | input | 1 | 1: byte-addressed register port, 0: word-indexed |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data for `reg_addr` (combinational) |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | ADDR_W | Byte address of the requested pixel word |
| rsp_valid | input | 1 | Returned word valid (in request order) |
| rsp_data | input | DATA_W | Returned pixel word |
| pix_valid | output | 1 | Pixel strobe |
| pix_red | output | CH_W | Red level |
| pix_green | output | CH_W | Green level |
| pix_blue | output | CH_W | Blue level |
| pix_x | output | XW | Pixel column |
| pix_y | output | YW | Pixel row |

## Verification
Some internal faults show up on the very next accepted request as a wrong address: a corrupted column or row counter, a mirror that is applied or missing, or a stage-to-active copy made at the wrong time. Other faults take longer to appear. A wrap counted incorrectly shows only at the frame boundary, where the request after the last pixel must return to the first one. An active copy made mid-frame shows only in the requests that follow the register write. A drifting response counter shows up one cycle after the next returned word, as a wrong `pix_x`/`pix_y`.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_ROT_BIT = 1;

   typedef struct packed {
      logic rot;
      logic en;
   } fbs_ctrl_t;
endpackage

// File: rtl/fbs_regs.sv
module fbs_regs
   import fbs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BASE_KEEP = 11,
   parameter int REG_AW    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_mode,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [ADDR_W-1:0]    wdata,
   output logic [ADDR_W-1:0]    rdata,
   output logic [BASE_KEEP-1:0] base_q,
   output fbs_ctrl_t            ctrl_q
);
   localparam int LOW_W = ADDR_W - BASE_KEEP;
   localparam logic [REG_AW-1:0] IDX_BASE      = '0;
   localparam logic [REG_AW-1:0] IDX_CTRL_WORD = REG_AW'(1);
   localparam logic [REG_AW-1:0] IDX_CTRL_BYTE = REG_AW'(4);

   logic sel_base, sel_ctrl;
   logic unused_wbits;

   assign sel_base = (addr == IDX_BASE);
   assign sel_ctrl = byte_mode ? (addr == IDX_CTRL_BYTE) : (addr == IDX_CTRL_WORD);
   assign unused_wbits = ^wdata[LOW_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         if (sel_base) base_q <= wdata[ADDR_W-1 -: BASE_KEEP];
         if (sel_ctrl) begin
            ctrl_q.en  <= wdata[CTRL_EN_BIT];
            ctrl_q.rot <= wdata[CTRL_ROT_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_base)      rdata = {base_q, {LOW_W{1'b0}}};
      else if (sel_ctrl) rdata = {{(ADDR_W-2){1'b0}}, ctrl_q};
   end

   a_r4_base_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_base) |=> (base_q == $past(wdata[ADDR_W-1 -: BASE_KEEP])));
   a_r4_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_ctrl) |=> (ctrl_q == $past(wdata[1:0])));
   a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel_base && !sel_ctrl) |=> ($stable(base_q) && $stable(ctrl_q)));
endmodule

// File: rtl/fbs_walker.sv
module fbs_walker
   import fbs_pkg::*;
#(
   parameter int H_VIS      = 640,
   parameter int V_VIS      = 480,
   parameter int ROW_WORDS  = 1024,
   parameter int ADDR_W     = 32,
   parameter int BASE_KEEP  = 11,
   parameter bit HAS_ROTATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BASE_KEEP-1:0] stage_base,
   input  fbs_ctrl_t            stage_ctrl,
   output logic                 rd_valid,
   input  logic                 rd_ready,
   output logic [ADDR_W-1:0]    rd_addr
);
   localparam int XW     = $clog2(H_VIS);
   localparam int YW     = $clog2(V_VIS);
   localparam int CW     = $clog2(ROW_WORDS);
   localparam int ROW_SH = CW + 2;
   localparam int LOW_W  = ADDR_W - BASE_KEEP;
   localparam logic [XW-1:0] X_LAST = XW'(H_VIS - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_VIS - 1);
   localparam logic [CW-1:0] C_LAST = CW'(H_VIS - 1);

   logic                 sof;
   logic [BASE_KEEP-1:0] act_base;
   logic                 act_en, act_rot;
   logic [XW-1:0]        cx, col;
   logic [YW-1:0]        cy, row;
   logic [LOW_W-1:0]     off;
   logic                 take, row_end, frame_end;

   assign rd_valid  = !sof && act_en;
   assign take      = rd_valid && rd_ready;
   assign row_end   = (cx == X_LAST);
   assign frame_end = row_end && (cy == Y_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sof      <= 1'b1;
         act_base <= '0;
         act_en   <= 1'b0;
         act_rot  <= 1'b0;
         cx       <= '0;
         cy       <= '0;
      end else if (sof) begin
         act_base <= stage_base;
         act_en   <= stage_ctrl.en;
         act_rot  <= stage_ctrl.rot;
         if (stage_ctrl.en) sof <= 1'b0;
      end else if (take) begin
         if (frame_end) begin
            cx  <= '0;
            cy  <= '0;
            sof <= 1'b1;
         end else if (row_end) begin
            cx <= '0;
            cy <= cy + 1'b1;
         end else begin
            cx <= cx + 1'b1;
         end
      end
   end

   generate
      if (HAS_ROTATE) begin : g_rot
         assign col = act_rot ? (X_LAST - cx) : cx;
         assign row = act_rot ? (Y_LAST - cy) : cy;
      end else begin : g_fwd
         assign col = cx;
         assign row = cy;
      end
   endgenerate

   always_comb begin
      off = (LOW_W'(row) << ROW_SH) | (LOW_W'(col) << 2);
   end
   assign rd_addr = {act_base, off};

   a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((rd_addr[ROW_SH-1:2] <= C_LAST) && (rd_addr[1:0] == 2'b00)));
   a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
   a_r7_base_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid)) |->
         (rd_addr[ADDR_W-1 -: BASE_KEEP] == $past(rd_addr[ADDR_W-1 -: BASE_KEEP])));
   a_r10_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (take && frame_end) |=> !rd_valid);
endmodule

// File: rtl/fbs_unpack.sv
module fbs_unpack #(
   parameter int H_VIS  = 640,
   parameter int V_VIS  = 480,
   parameter int DATA_W = 32,
   parameter int CH_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rsp_valid,
   input  logic [DATA_W-1:0]        rsp_data,
   output logic                     pix_valid,
   output logic [CH_W-1:0]          pix_red,
   output logic [CH_W-1:0]          pix_green,
   output logic [CH_W-1:0]          pix_blue,
   output logic [$clog2(H_VIS)-1:0] pix_x,
   output logic [$clog2(V_VIS)-1:0] pix_y
);
   localparam int NCH = 3;
   localparam int XW  = $clog2(H_VIS);
   localparam int YW  = $clog2(V_VIS);
   localparam logic [XW-1:0] X_LAST = XW'(H_VIS - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_VIS - 1);

   logic [CH_W-1:0] chan_d [NCH];
   logic [XW-1:0]   rx;
   logic [YW-1:0]   ry;
   logic            unused_hi;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign chan_d[i] = rsp_data[(NCH-1-i)*CH_W +: CH_W];
      end
   endgenerate
   assign unused_hi = ^rsp_data[DATA_W-1:NCH*CH_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx        <= '0;
         ry        <= '0;
         pix_valid <= 1'b0;
         pix_red   <= '0;
         pix_green <= '0;
         pix_blue  <= '0;
         pix_x     <= '0;
         pix_y     <= '0;
      end else begin
         pix_valid <= rsp_valid;
         pix_red   <= rsp_valid ? chan_d[0] : '0;
         pix_green <= rsp_valid ? chan_d[1] : '0;
         pix_blue  <= rsp_valid ? chan_d[2] : '0;
         if (rsp_valid) begin
            pix_x <= rx;
            pix_y <= ry;
            if (rx == X_LAST) begin
               rx <= '0;
               ry <= (ry == Y_LAST) ? '0 : ry + 1'b1;
            end else begin
               rx <= rx + 1'b1;
            end
         end
      end
   end

   a_r6_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> ((pix_red == '0) && (pix_green == '0) && (pix_blue == '0)));
   a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> pix_valid);
endmodule

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
   import fbs_pkg::*;
#(
   parameter int H_VIS      = 640,
   parameter int V_VIS      = 480,
   parameter int ROW_WORDS  = 1024,
   parameter int ADDR_W     = 32,
   parameter int BASE_KEEP  = 11,
   parameter int REG_AW     = 4,
   parameter int DATA_W     = 32,
   parameter int CH_W       = 8,
   parameter bit HAS_ROTATE = 1'b1,
   parameter int XW         = $clog2(H_VIS),
   parameter int YW         = $clog2(V_VIS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_byte_addr,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              pix_valid,
   output logic [CH_W-1:0]   pix_red,
   output logic [CH_W-1:0]   pix_green,
   output logic [CH_W-1:0]   pix_blue,
   output logic [XW-1:0]     pix_x,
   output logic [YW-1:0]     pix_y
);
   localparam int LOW_W      = ADDR_W - BASE_KEEP;
   localparam longint SPAN_B = longint'(V_VIS) * ROW_WORDS * 4;

   generate
      if ((ROW_WORDS & (ROW_WORDS - 1)) != 0) begin : g_chk_pitch
         $error("ROW_WORDS must be a power of two");
      end
      if (H_VIS > ROW_WORDS) begin : g_chk_width
         $error("H_VIS exceeds the row pitch");
      end
      if (SPAN_B > (longint'(1) << LOW_W)) begin : g_chk_span
         $error("frame does not fit below the kept base bits");
      end
      if (DATA_W <= 3 * CH_W) begin : g_chk_data
         $error("DATA_W must exceed three channels");
      end
      if (REG_AW < 3) begin : g_chk_raw
         $error("REG_AW too small for byte addressing");
      end
      if (XW != $clog2(H_VIS) || YW != $clog2(V_VIS)) begin : g_chk_pos
         $error("XW/YW must not be overridden");
      end
   endgenerate

   logic [BASE_KEEP-1:0] stage_base;
   fbs_ctrl_t            stage_ctrl;

   fbs_regs #(
      .ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_mode(cfg_byte_addr), .wr_en(reg_wr_en),
      .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .base_q(stage_base), .ctrl_q(stage_ctrl)
   );

   fbs_walker #(
      .H_VIS(H_VIS), .V_VIS(V_VIS), .ROW_WORDS(ROW_WORDS), .ADDR_W(ADDR_W),
      .BASE_KEEP(BASE_KEEP), .HAS_ROTATE(HAS_ROTATE)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .stage_base(stage_base), .stage_ctrl(stage_ctrl),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr)
   );

   fbs_unpack #(
      .H_VIS(H_VIS), .V_VIS(V_VIS), .DATA_W(DATA_W), .CH_W(CH_W)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
      .pix_blue(pix_blue), .pix_x(pix_x), .pix_y(pix_y)
   );

   a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!stage_ctrl.en) && !stage_ctrl.en && !rd_valid) |=> !rd_valid);
endmodule

// File: tb/fb_scan_ctrl_tb.sv
module fb_scan_ctrl_tb;
   localparam int H = 12;
   localparam int V = 5;
   localparam int RW = 16;
   localparam int XW = $clog2(H);
   localparam int YW = $clog2(V);

   typedef struct packed {
      logic        bm;
      logic        wr;
      logic [3:0]  wa;
      logic [31:0] wd;
      logic [3:0]  ra;
      logic [31:0] ex;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 4'd0, 32'h0,          4'd0, 32'h0},          // R1 base
      '{1'b0, 1'b0, 4'd0, 32'h0,          4'd1, 32'h0},          // R1 ctrl
      '{1'b1, 1'b1, 4'd0, 32'h1234_5678,  4'd0, 32'h1220_0000},  // R4 base keep
      '{1'b1, 1'b1, 4'd4, 32'hFFFF_FFFE,  4'd4, 32'h2},          // R4 ctrl bits
      '{1'b0, 1'b0, 4'd0, 32'h0,          4'd1, 32'h2},          // R2 word idx 1
      '{1'b0, 1'b0, 4'd0, 32'h0,          4'd4, 32'h0},          // R2 unmapped
      '{1'b1, 1'b0, 4'd0, 32'h0,          4'd1, 32'h0},          // R2 unmapped
      '{1'b0, 1'b1, 4'd3, 32'h3,          4'd1, 32'h2},          // R2 stray write
      '{1'b1, 1'b1, 4'd1, 32'h3,          4'd4, 32'h2},          // R2 stray write
      '{1'b0, 1'b1, 4'd1, 32'h0,          4'd1, 32'h0}           // R2 clear
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_byte_addr = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic rd_valid, rd_ready = 1'b0;
   logic [31:0] rd_addr;
   logic rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic pix_valid;
   logic [7:0] pix_red, pix_green, pix_blue;
   logic [XW-1:0] pix_x;
   logic [YW-1:0] pix_y;

   int total = 0, bad = 0;
   bit finished = 0;
   int mx = 0, my = 0, accepted = 0;
   logic [31:0] exp_base = '0;
   bit exp_rot = 0;

   always #10 clk = ~clk;

   fb_scan_ctrl #(.H_VIS(H), .V_VIS(V), .ROW_WORDS(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_byte_addr(cfg_byte_addr),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
      .pix_blue(pix_blue), .pix_x(pix_x), .pix_y(pix_y)
   );

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mkdata(logic [31:0] a);
      return {8'hC3, a[7:0] ^ 8'h3C, a[15:8], a[23:16]};
   endfunction

   function automatic logic [31:0] exp_addr(int x, int y);
      int r, c;
      r = exp_rot ? (V - 1 - y) : y;
      c = exp_rot ? (H - 1 - x) : x;
      return exp_base + 32'(r * RW * 4) + 32'(c * 4);
   endfunction

   task automatic wr_reg(bit bm, logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_byte_addr = bm; reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic run_px(int n);
      int got = 0, cyc = 0;
      bit acc_prev = 0, pend = 0, stall_prev = 0;
      logic [31:0] a_prev = '0, a_pix = '0, stall_addr = '0;
      int ax = 0, ay = 0, px = 0, py = 0;
      logic [31:0] ea;
      while (got < n || acc_prev || pend) begin
         @(negedge clk);
         cyc++;
         if (pend) begin
            chk(pix_valid == 1'b1, "R9", "pix_valid", 32'(pix_valid), 32'd1);
            chk({pix_red, pix_green, pix_blue} == {a_pix[7:0] ^ 8'h3C, a_pix[15:8], a_pix[23:16]},
                "R9", "rgb", {8'h0, pix_red, pix_green, pix_blue},
                {8'h0, a_pix[7:0] ^ 8'h3C, a_pix[15:8], a_pix[23:16]});
            chk(pix_x == XW'(px) && pix_y == YW'(py), "R9", "position",
                {16'(pix_y), 16'(pix_x)}, {16'(py), 16'(px)});
         end else begin
            chk(!pix_valid && {pix_red, pix_green, pix_blue} == 24'h0, "R9", "idle pixel",
                {7'h0, pix_valid, pix_red, pix_green, pix_blue}, 32'h0);
         end
         rsp_valid = acc_prev;
         rsp_data  = acc_prev ? mkdata(a_prev) : 32'h0;
         pend = acc_prev; a_pix = a_prev; px = ax; py = ay;
         if (stall_prev)
            chk(rd_valid && rd_addr == stall_addr, "R8", "held request", rd_addr, stall_addr);
         acc_prev = 0; stall_prev = 0;
         if (got < n) begin
            rd_ready = (cyc % 3) != 1;
            if (rd_valid && rd_ready) begin
               ea = exp_addr(mx, my);
               if (mx == 0 && my == 0 && accepted > 0)
                  chk(rd_addr == ea, "R10", "frame wrap address", rd_addr, ea);
               else if (exp_rot)
                  chk(rd_addr == ea, "R5", "rotated address", rd_addr, ea);
               else
                  chk(rd_addr == ea, "R3", "address", rd_addr, ea);
               a_prev = rd_addr; ax = mx; ay = my; acc_prev = 1;
               got++; accepted++;
               if (mx == H - 1) begin
                  mx = 0;
                  my = (my == V - 1) ? 0 : my + 1;
               end else mx++;
            end
            stall_prev = rd_valid && !rd_ready;
            stall_addr = rd_addr;
         end else rd_ready = 1'b0;
      end
      rsp_valid = 1'b0;
      rd_ready  = 1'b0;
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk(!rd_valid, "R1", "rd_valid after reset", 32'(rd_valid), 32'h0);
         chk(!pix_valid && {pix_red, pix_green, pix_blue} == 24'h0, "R1", "pixels after reset",
             {7'h0, pix_valid, pix_red, pix_green, pix_blue}, 32'h0);
      end

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) wr_reg(VECS[i].bm, VECS[i].wa, VECS[i].wd);
         else @(negedge clk);
         cfg_byte_addr = VECS[i].bm;
         reg_addr = VECS[i].ra;
         #1;
         chk(reg_rdata == VECS[i].ex, (i < 2) ? "R1" : ((i < 4) ? "R4" : "R2"),
             "register read", reg_rdata, VECS[i].ex);
         chk(!rd_valid, "R6", "no request while disabled", 32'(rd_valid), 32'h0);
      end

      exp_base = 32'h1220_0000; exp_rot = 0;
      wr_reg(1'b0, 4'd1, 32'h1);
      run_px(30);
      wr_reg(1'b0, 4'd1, 32'h3);
      run_px(30);                    // R7: rest of frame stays unrotated
      exp_rot = 1;
      run_px(H * V);                 // R5 whole rotated frame
      run_px(20);
      wr_reg(1'b1, 4'd0, 32'h4000_0000);
      run_px(H * V - 20);            // R7: old base until frame end
      exp_base = 32'h4000_0000;
      run_px(H * V);
      run_px(30);
      wr_reg(1'b1, 4'd4, 32'h0);
      run_px(H * V - 30);            // R7: disable waits for frame end
      rd_ready = 1'b1;
      repeat (20) begin
         @(negedge clk);
         chk(!rd_valid, "R6", "no request after disable", 32'(rd_valid), 32'h0);
         chk({pix_red, pix_green, pix_blue} == 24'h0, "R6", "colour blank",
             {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
      end
      rd_ready = 1'b0;

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule